// File: doc/BRIEF.md
# Circular Buffer Flag Generator

This block watches the write and read pointers of a dual-clock circular frame buffer and derives its status from them. The pointers arrive already brought into the read clock domain. From them it produces a pointer-equality (collision) flag, an almost-empty flag, an almost-full flag and a per-cycle permit that tells the read-address counter whether it may step forward. The buffer never stalls its writer. Once full, new samples overwrite the oldest unread ones.

In FIFO mode the reader is held on its current address whenever it has caught up with the writer, so the most recent sample is presented again until more data lands. In random-access mode that hold never applies and the reader advances whenever it is enabled. Both warning flags compare a ring distance, taken modulo the memory depth, against a threshold that is a whole number of eightieths of the depth. Software programs that number while the load strobe is low, and the block latches it. A pointer set or clear issued while the load strobe is high switches off the read hold permanently and marks the flags as no longer trustworthy until the next reset.

Top module: `cbuf_flag_gen`

## Requirements
- R1: `collide_o` is high in the cycle after a clock edge at which `wr_ptr_i` equals `rd_ptr_i`, and low in the cycle after an edge at which they differ.
- R2: `near_empty_o` is high in the cycle after an edge at which the unread gap (`wr_ptr_i` − `rd_ptr_i`) mod DEPTH is strictly below the empty threshold. The threshold is floor(k × DEPTH / 80), with k taken from `empty_k_i`. A k above 80 counts as 80, and a k of 0 (or any k giving a threshold of 0) keeps the flag low.
- R3: `near_full_o` is high in the cycle after an edge at which the read lead (`rd_ptr_i` − `wr_ptr_i`) mod DEPTH is strictly below floor(k × DEPTH / 80), with k taken from `full_k_i` under the same clamp and zero rule as R2.
- R4: Both distances wrap correctly when DEPTH is not a power of two. For example, with DEPTH = 100, write 3 and read 95 give a gap of 8.
- R5: Thresholds are latched from `empty_k_i`/`full_k_i` at each edge where `load_i` is low. Changes to these inputs while `load_i` is high have no effect on the flags.
- R6: While the read hold is active and the mode is FIFO (`rand_mode_i` = 0), `rd_adv_o` is low whenever `wr_ptr_i` equals `rd_ptr_i`. Otherwise, with `rd_en_i` high, it is high.
- R7: `rd_adv_o` is never high while `rd_en_i` is low.
- R8: With `rand_mode_i` = 1, `rd_adv_o` follows `rd_en_i` even when the pointers are equal.
- R9: A clock edge with `ptr_jump_i` and `load_i` both high drives `flags_ok_o` low from the next cycle on and disables the read hold. Both effects last until reset.
- R10: A `ptr_jump_i` pulse while `load_i` is low changes neither `flags_ok_o` nor the read hold.
- R11: After a synchronous reset, all three flags are low, `flags_ok_o` is high, both thresholds are zero, and the read hold is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_ptr_i | input | PTR_W | Write pointer, synchronized into this domain |
| rd_ptr_i | input | PTR_W | Current read pointer |
| load_i | input | 1 | High once configuration is complete; low lets thresholds be latched |
| ptr_jump_i | input | 1 | One-cycle pulse: a pointer set or clear event |
| rd_en_i | input | 1 | Read enable request from the read controller |
| rand_mode_i | input | 1 | 0 = FIFO mode with read hold, 1 = random-access mode |
| empty_k_i | input | 7 | Almost-empty threshold in eightieths of DEPTH |
| full_k_i | input | 7 | Almost-full threshold in eightieths of DEPTH |
| collide_o | output | 1 | Pointers were equal at the previous edge |
| near_empty_o | output | 1 | Almost-empty flag |
| near_full_o | output | 1 | Almost-full flag |
| rd_adv_o | output | 1 | Read pointer may advance this cycle |
| flags_ok_o | output | 1 | Flags are valid (no jump seen since reset) |

## Verification
The bench builds the block with DEPTH = 100. Because this depth is not a power of two, the modulo step of the distance logic is actually exercised: the pointers wrap at 99 rather than at a bit boundary, so a plain subtraction would give wrong flags. The depth is also not a multiple of 80, so thresholds such as 3/80 (3.75 → 3) and 79/80 (98.75 → 98) check that the floor is applied. Threshold edges can be probed one sample either side, the clamp at k = 90 reaches the full depth, and the sticky invalidation is checked across reset.

// File: rtl/cbfg_pkg.sv
package cbfg_pkg;

    localparam int K_W   = 7;
    localparam int K_MAX = 80;

    typedef enum logic {
        MODE_FIFO   = 1'b0,
        MODE_RANDOM = 1'b1
    } rd_mode_e;

    typedef struct packed {
        logic collide;
        logic near_empty;
        logic near_full;
    } flag_set_t;

    function automatic logic [K_W-1:0] clamp_k(input logic [K_W-1:0] k);
        return (k > K_W'(K_MAX)) ? K_W'(K_MAX) : k;
    endfunction

endpackage

// File: rtl/cbfg_thr.sv
module cbfg_thr
    import cbfg_pkg::*;
#(
    parameter int DEPTH = 1 << 20
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load_i,
    input  logic [K_W-1:0]           k_i,
    output logic [$clog2(DEPTH):0]   thr_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int DW    = PTR_W + 1;
    localparam int PW    = PTR_W + K_W + 1;

    logic [PW-1:0] prod;
    logic [DW-1:0] thr_d;
    logic [DW-1:0] thr_q;

    always_comb begin
        prod  = PW'(clamp_k(k_i)) * PW'(DEPTH);
        thr_d = DW'(prod / PW'(K_MAX));
    end

    always_ff @(posedge clk) begin
        if (rst)
            thr_q <= '0;
        else if (!load_i)
            thr_q <= thr_d;
    end

    assign thr_o = thr_q;

    // R5: latched threshold is frozen while configuration is closed
    a_r5_thr_frozen: assert property (@(posedge clk) disable iff (rst)
        load_i |=> $stable(thr_q));

endmodule

// File: rtl/cbfg_flags.sv
module cbfg_flags
    import cbfg_pkg::*;
#(
    parameter int DEPTH = 1 << 20
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [$clog2(DEPTH)-1:0]     wr_ptr_i,
    input  logic [$clog2(DEPTH)-1:0]     rd_ptr_i,
    input  logic [$clog2(DEPTH):0]       empty_thr_i,
    input  logic [$clog2(DEPTH):0]       full_thr_i,
    output flag_set_t                    flags_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int DW    = PTR_W + 1;

    function automatic logic [DW-1:0] ring_dist(input logic [PTR_W-1:0] a,
                                                input logic [PTR_W-1:0] b);
        if (a >= b)
            return {1'b0, a} - {1'b0, b};
        else
            return {1'b0, a} + DW'(DEPTH) - {1'b0, b};
    endfunction

    logic [DW-1:0] gap;
    logic [DW-1:0] lead;
    flag_set_t     flg_d;
    flag_set_t     flg_q;

    always_comb begin
        gap              = ring_dist(wr_ptr_i, rd_ptr_i);
        lead             = ring_dist(rd_ptr_i, wr_ptr_i);
        flg_d.collide    = (wr_ptr_i == rd_ptr_i);
        flg_d.near_empty = (gap  < empty_thr_i);
        flg_d.near_full  = (lead < full_thr_i);
    end

    always_ff @(posedge clk) begin
        if (rst)
            flg_q <= '0;
        else
            flg_q <= flg_d;
    end

    assign flags_o = flg_q;

    // R1: equal pointers raise the collision flag one cycle later
    a_r1_collide_set: assert property (@(posedge clk) disable iff (rst)
        (wr_ptr_i == rd_ptr_i) |=> flg_q.collide);
    a_r1_collide_clr: assert property (@(posedge clk) disable iff (rst)
        (wr_ptr_i != rd_ptr_i) |=> !flg_q.collide);
    // R2: a zero threshold keeps the almost-empty flag low
    a_r2_empty_off: assert property (@(posedge clk) disable iff (rst)
        (empty_thr_i == '0) |=> !flg_q.near_empty);

endmodule

// File: rtl/cbfg_gate.sv
module cbfg_gate
    import cbfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load_i,
    input  logic     ptr_jump_i,
    input  logic     rd_en_i,
    input  rd_mode_e mode_i,
    input  logic     ptr_eq_i,
    output logic     rd_adv_o,
    output logic     flags_ok_o
);
    logic hold_off_q;

    always_ff @(posedge clk) begin
        if (rst)
            hold_off_q <= 1'b0;
        else if (ptr_jump_i && load_i)
            hold_off_q <= 1'b1;
    end

    always_comb begin
        rd_adv_o = 1'b0;
        if (rd_en_i) begin
            unique case (mode_i)
                MODE_RANDOM: rd_adv_o = 1'b1;
                MODE_FIFO:   rd_adv_o = hold_off_q || !ptr_eq_i;
                default:     rd_adv_o = 1'b0;
            endcase
        end
    end

    assign flags_ok_o = !hold_off_q;

    // R9: qualified jump invalidates flags from the next cycle
    a_r9_jump_kills: assert property (@(posedge clk) disable iff (rst)
        (ptr_jump_i && load_i) |=> !flags_ok_o);
    // R9: invalidation is sticky until reset
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        !flags_ok_o |=> !flags_ok_o);
    // R10: without load, a jump leaves validity untouched
    a_r10_no_effect: assert property (@(posedge clk) disable iff (rst)
        (flags_ok_o && !(ptr_jump_i && load_i)) |=> flags_ok_o);
    // R6: active hold in FIFO mode blocks the advance on equality
    a_r6_halt: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_FIFO && flags_ok_o && ptr_eq_i) |-> !rd_adv_o);
    // R7: no advance without an enable
    a_r7_needs_en: assert property (@(posedge clk) disable iff (rst)
        rd_adv_o |-> rd_en_i);

endmodule

// File: rtl/cbuf_flag_gen.sv
module cbuf_flag_gen
    import cbfg_pkg::*;
#(
    parameter int DEPTH = 1 << 20,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PTR_W-1:0] wr_ptr_i,
    input  logic [PTR_W-1:0] rd_ptr_i,
    input  logic             load_i,
    input  logic             ptr_jump_i,
    input  logic             rd_en_i,
    input  logic             rand_mode_i,
    input  logic [K_W-1:0]   empty_k_i,
    input  logic [K_W-1:0]   full_k_i,
    output logic             collide_o,
    output logic             near_empty_o,
    output logic             near_full_o,
    output logic             rd_adv_o,
    output logic             flags_ok_o
);
    localparam int DW    = PTR_W + 1;
    localparam int N_THR = 2;

    logic [K_W-1:0] k_sel [N_THR];
    logic [DW-1:0]  thr   [N_THR];
    flag_set_t      flags;

    assign k_sel[0] = empty_k_i;
    assign k_sel[1] = full_k_i;

    for (genvar g = 0; g < N_THR; g++) begin : g_thr
        cbfg_thr #(.DEPTH(DEPTH)) u_thr (
            .clk    (clk),
            .rst    (rst),
            .load_i (load_i),
            .k_i    (k_sel[g]),
            .thr_o  (thr[g])
        );
    end

    cbfg_flags #(.DEPTH(DEPTH)) u_flags (
        .clk         (clk),
        .rst         (rst),
        .wr_ptr_i    (wr_ptr_i),
        .rd_ptr_i    (rd_ptr_i),
        .empty_thr_i (thr[0]),
        .full_thr_i  (thr[1]),
        .flags_o     (flags)
    );

    cbfg_gate u_gate (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load_i),
        .ptr_jump_i (ptr_jump_i),
        .rd_en_i    (rd_en_i),
        .mode_i     (rd_mode_e'(rand_mode_i)),
        .ptr_eq_i   (wr_ptr_i == rd_ptr_i),
        .rd_adv_o   (rd_adv_o),
        .flags_ok_o (flags_ok_o)
    );

    assign collide_o    = flags.collide;
    assign near_empty_o = flags.near_empty;
    assign near_full_o  = flags.near_full;

endmodule

// File: tb/cbuf_flag_gen_tb.sv
module cbuf_flag_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 100;
    localparam int PTR_W      = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [PTR_W-1:0] wr_ptr = '0;
    logic [PTR_W-1:0] rd_ptr = '0;
    logic             load = 1'b0;
    logic             jump = 1'b0;
    logic             rd_en = 1'b0;
    logic             rmode = 1'b0;
    logic [6:0]       ek = '0;
    logic [6:0]       fk = '0;
    logic             collide, nempty, nfull, rd_adv, fok;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cbuf_flag_gen #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .wr_ptr_i(wr_ptr), .rd_ptr_i(rd_ptr),
        .load_i(load), .ptr_jump_i(jump), .rd_en_i(rd_en), .rand_mode_i(rmode),
        .empty_k_i(ek), .full_k_i(fk), .collide_o(collide), .near_empty_o(nempty),
        .near_full_o(nfull), .rd_adv_o(rd_adv), .flags_ok_o(fok)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic got, input logic exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic set_thr(input logic [6:0] e, input logic [6:0] f);
        load = 1'b0; ek = e; fk = f;
        step();
        load = 1'b1;
    endtask

    task automatic ptrs(input int w, input int r);
        wr_ptr = PTR_W'(w); rd_ptr = PTR_W'(r);
        step();
    endtask

    task automatic t_reset();
        rst = 1'b1; step(); step(); rst = 1'b0;
        chk(collide, 1'b0, "R11 collide");
        chk(nempty,  1'b0, "R11 near_empty");
        chk(nfull,   1'b0, "R11 near_full");
        chk(fok,     1'b1, "R11 flags_ok");
    endtask

    task automatic t_collide();
        ptrs(50, 50); chk(collide, 1'b1, "R1 equal");
        ptrs(51, 50); chk(collide, 1'b0, "R1 differ");
    endtask

    task automatic t_empty();
        set_thr(7'd8, 7'd0);                       // threshold 10
        ptrs(15, 6);  chk(nempty, 1'b1, "R2 gap 9");
        chk(nfull, 1'b0, "R3 k=0 off");
        ptrs(15, 5);  chk(nempty, 1'b0, "R2 gap 10");
        set_thr(7'd3, 7'd0);                       // floor(3.75)=3
        ptrs(12, 10); chk(nempty, 1'b1, "R2 floor gap 2");
        ptrs(13, 10); chk(nempty, 1'b0, "R2 floor gap 3");
        set_thr(7'd90, 7'd0);                      // clamped to 100
        ptrs(99, 0);  chk(nempty, 1'b1, "R2 clamp gap 99");
        set_thr(7'd0, 7'd0);
        ptrs(11, 10); chk(nempty, 1'b0, "R2 k=0 off");
    endtask

    task automatic t_wrap();
        set_thr(7'd8, 7'd8);
        ptrs(3, 95);  chk(nempty, 1'b1, "R4 wrap gap 8");
        ptrs(3, 93);  chk(nempty, 1'b0, "R4 wrap gap 10");
        ptrs(95, 4);  chk(nfull,  1'b1, "R4 wrap lead 9");
    endtask

    task automatic t_full();
        set_thr(7'd0, 7'd8);
        ptrs(11, 20); chk(nfull, 1'b1, "R3 lead 9");
        ptrs(10, 20); chk(nfull, 1'b0, "R3 lead 10");
        set_thr(7'd0, 7'd79);                      // floor(98.75)=98
        ptrs(0, 97);  chk(nfull, 1'b1, "R3 lead 97");
        ptrs(0, 98);  chk(nfull, 1'b0, "R3 lead 98");
    endtask

    task automatic t_hold_cfg();
        set_thr(7'd8, 7'd0);
        ek = 7'd0;                                 // load high: ignored
        step();
        ptrs(15, 6);  chk(nempty, 1'b1, "R5 cfg frozen");
    endtask

    task automatic t_halt();
        rmode = 1'b0; rd_en = 1'b1; wr_ptr = 7'd40; rd_ptr = 7'd40; #1;
        chk(rd_adv, 1'b0, "R6 halt on equal");
        rd_ptr = 7'd39; #1;
        chk(rd_adv, 1'b1, "R6 advance");
        rd_en = 1'b0; #1;
        chk(rd_adv, 1'b0, "R7 no enable");
        rmode = 1'b1; rd_en = 1'b1; rd_ptr = 7'd40; #1;
        chk(rd_adv, 1'b1, "R8 random no halt");
        rd_en = 1'b0; #1;
        chk(rd_adv, 1'b0, "R8 random needs enable");
        rmode = 1'b0; rd_en = 1'b1; step();
    endtask

    task automatic t_jump_noload();
        load = 1'b0; jump = 1'b1; step(); jump = 1'b0; load = 1'b1; step();
        chk(fok, 1'b1, "R10 flags_ok kept");
        wr_ptr = 7'd20; rd_ptr = 7'd20; #1;
        chk(rd_adv, 1'b0, "R10 hold kept");
    endtask

    task automatic t_jump_load();
        load = 1'b1; jump = 1'b1; step(); jump = 1'b0;
        chk(fok, 1'b0, "R9 invalidated");
        wr_ptr = 7'd20; rd_ptr = 7'd20; rmode = 1'b0; rd_en = 1'b1; #1;
        chk(rd_adv, 1'b1, "R9 hold disabled");
        step(); step();
        chk(fok, 1'b0, "R9 sticky");
        rst = 1'b1; step(); rst = 1'b0; #1;
        chk(fok, 1'b1, "R11 flags_ok after reset");
        chk(rd_adv, 1'b0, "R11 hold active after reset");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_collide();
        t_empty();
        t_wrap();
        t_full();
        t_hold_cfg();
        t_halt();
        t_jump_noload();
        t_jump_load();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule